// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the interrupt control register of a small 8-bit microcontroller core. It holds one enable bit and one sticky flag bit for each of three local interrupt sources: a timer overflow, a rising edge on an external input, and a change on any of six general-purpose I/O pins. It also holds a master enable and an enable for a separate group of peripheral requests, which arrives as a single input. The block combines these into one interrupt request line for the core.

The core reaches the block through a small register port with three addresses. Address 0 is the control register. Address 1 is a 6-bit per-pin change mask. Address 2 reads the synchronized I/O pins, and that read also reloads the snapshot the change detector compares against. Flags are set whatever the enables say and are only cleared by software. The request output is combinational from the stored bits and the peripheral input.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After reset the control register reads 0x00, the change mask reads 0x00 and `irqOut` is 0.
- R2: A write to address 0 loads all eight bits and a read of address 0 returns them. The bits from 7 down to 3 are master enable, peripheral enable, timer enable, external-edge enable and pin-change enable.
- R3: Flag bits are set by their events even when the matching enable and the master enable are 0.
- R4: A set flag stays set until software writes 0 to it; hardware never clears a flag.
- R5: A one-cycle `tmrOverflow` pulse sets bit 2 at the next clock edge.
- R6: A rising edge on `extPin` passes a two-stage synchronizer and sets bit 1 at the third clock edge after the pin changes; a falling edge sets nothing.
- R7: Bit 0 is set, at the third clock edge after a pin change, whenever any synchronized pin whose mask bit is 1 differs from the stored snapshot; a pin whose mask bit is 0 has no effect.
- R8: A read of address 2 with `regRdEn` high returns the synchronized pins in bits 5..0 and reloads the snapshot, so a mismatch that software has seen stops setting bit 0.
- R9: `irqOut` equals bit 7 AND ((bit 5 AND bit 2) OR (bit 4 AND bit 1) OR (bit 3 AND bit 0) OR (bit 6 AND `periphIrq`)).
- R10: `periphIrq` reaches `irqOut` only while both bit 6 and bit 7 are 1.
- R11: When a flag event and a software write of 0 to that flag fall in the same cycle, the flag ends up set.
- R12: Address 1 stores bits 5..0 of a write; a read returns them with bits 7..6 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (re-arms change detect at address 2) |
| regAddr | input | 2 | Register address: 0 control, 1 mask, 2 pins |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| tmrOverflow | input | 1 | One-cycle pulse on timer rollover |
| extPin | input | 1 | Asynchronous external interrupt input |
| ioPins | input | 6 | Asynchronous I/O pin levels |
| periphIrq | input | 1 | Combined peripheral interrupt request |
| irqOut | output | 1 | Interrupt request to the core |

## Verification
A hardware flag set and a software write to the control register can fall in the same cycle. The bench provokes this by driving a `tmrOverflow` pulse in the very cycle that writes 0x00 to address 0, and expects bit 2 to read back as 1 afterwards. It also writes 0 to the pin-change flag while an unacknowledged mismatch is still present and expects the flag to come straight back, then shows it stays clear once a port read has re-armed the detector.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int PIN_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd2;

  // bit positions in the control register
  localparam int BIT_GEN = 7;
  localparam int BIT_PEN = 6;
  localparam int BIT_TEN = 5;
  localparam int BIT_XEN = 4;
  localparam int BIT_CEN = 3;
  localparam int BIT_TFL = 2;
  localparam int BIT_XFL = 1;
  localparam int BIT_CFL = 0;
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic rdPort;
  } strobes_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_ctrl_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb
);
  always_comb begin
    strb.wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
    strb.wrMask = regWrEn && (regAddr == ADDR_MASK);
    strb.rdPort = regRdEn && (regAddr == ADDR_PORT);
  end
endmodule

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              tmrOverflow,
  input  logic              extPin,
  input  logic [PIN_W-1:0]  ioPins,
  input  logic              periphIrq,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0]     maskQ;
  logic [PIN_W-1:0]     snapQ;
  logic [PIN_W-1:0]     pinSync;
  logic                 extSync;
  logic                 extPrevQ;
  logic                 extRise;
  logic                 pinChange;
  logic [NUM_FLAGS-1:0] setFlags;
  logic [DATA_W-1:0]    ctrlNext;

  irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_pinSync (
    .clk(clk), .rstN(rstN), .din(ioPins), .dout(pinSync)
  );

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extPin), .dout(extSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrevQ <= 1'b0;
    else       extPrevQ <= extSync;
  end

  assign extRise   = extSync & ~extPrevQ;
  assign pinChange = |((pinSync ^ snapQ) & maskQ);
  assign setFlags  = {tmrOverflow, extRise, pinChange};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snapQ <= '0;
    else if (strb.rdPort) snapQ <= pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strb.wrMask) maskQ <= regWrData[PIN_W-1:0];
  end

  always_comb begin
    ctrlNext = strb.wrCtrl ? regWrData : ctrlQ;
    ctrlNext[NUM_FLAGS-1:0] = ctrlNext[NUM_FLAGS-1:0] | setFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = ctrlQ;
      ADDR_MASK: regRdData = {{PAD_W{1'b0}}, maskQ};
      ADDR_PORT: regRdData = {{PAD_W{1'b0}}, pinSync};
      default:   regRdData = '0;
    endcase
  end

  assign irqOut = ctrlQ[BIT_GEN] &
                  ((ctrlQ[BIT_TEN] & ctrlQ[BIT_TFL]) |
                   (ctrlQ[BIT_XEN] & ctrlQ[BIT_XFL]) |
                   (ctrlQ[BIT_CEN] & ctrlQ[BIT_CFL]) |
                   (ctrlQ[BIT_PEN] & periphIrq));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tmrOverflow,
  input  logic              extPin,
  input  logic [PIN_W-1:0]  ioPins,
  input  logic              periphIrq,
  output logic              irqOut
);
  strobes_t          strb;
  logic [DATA_W-1:0] ctrlQ;

  irq_ctrl_decode u_decode (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strb(strb)
  );

  irq_ctrl_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .tmrOverflow(tmrOverflow), .extPin(extPin),
    .ioPins(ioPins), .periphIrq(periphIrq), .regRdData(regRdData),
    .ctrlQ(ctrlQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              tmrOverflow,
  input logic              periphIrq,
  input logic [DATA_W-1:0] ctrlQ,
  input logic              irqOut
);
  logic wrCtrlSeen;
  assign wrCtrlSeen = regWrEn && (regAddr == ADDR_CTRL);

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlSeen |=> ctrlQ[7:3] == $past(regWrData[7:3])); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_TFL] && !wrCtrlSeen) |=> ctrlQ[BIT_TFL]); // R4

  AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    tmrOverflow |=> ctrlQ[BIT_TFL]); // R5

  AST_SET_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrlSeen && !regWrData[BIT_TFL] && tmrOverflow) |=> ctrlQ[BIT_TFL]); // R11

  AST_MASTER_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[BIT_GEN] |-> !irqOut); // R9

  AST_PERIPH_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_GEN] && ctrlQ[BIT_PEN] && periphIrq) |-> irqOut); // R10
endmodule

bind irq_ctrl_reg irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .tmrOverflow(tmrOverflow), .periphIrq(periphIrq),
  .ctrlQ(ctrlQ), .irqOut(irqOut)
);

// File: tb/irq_ctrl_reg_bench.sv
module irq_ctrl_reg_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       tmrOverflow = 1'b0;
  logic       extPin = 1'b0;
  logic [5:0] ioPins = 6'd0;
  logic       periphIrq = 1'b0;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  irq_ctrl_reg u_irq_ctrl_reg (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tmrOverflow(tmrOverflow), .extPin(extPin), .ioPins(ioPins),
    .periphIrq(periphIrq), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  function automatic logic expIrq(input logic [7:0] v, input logic p);
    return v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic cpuRead(input logic [1:0] a, input bit strobe, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = strobe;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic peekCtrl(output logic [7:0] d);
    regAddr = 2'd0;
    #1 d = regRdData;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    cpuRead(2'd0, 1'b0, d); check("R1 ctrl", d, 8'h00);
    cpuRead(2'd1, 1'b0, d); check("R1 mask", d, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    // R12 mask register width
    cpuWrite(2'd1, 8'hFF);
    cpuRead(2'd1, 1'b0, d); check("R12 mask", d, 8'h3F);
    cpuWrite(2'd1, 8'h01);

    // R5 and R3: timer flag with all enables off
    @(negedge clk); tmrOverflow = 1'b1;
    @(negedge clk); tmrOverflow = 1'b0;
    peekCtrl(d); check("R5 R3 timer flag", d, 8'h04);
    check("R9 master off irq", {7'd0, irqOut}, 8'h00);

    // R4 sticky until written 0
    repeat (5) @(negedge clk);
    peekCtrl(d); check("R4 sticky", d, 8'h04);
    cpuWrite(2'd0, 8'h00);
    peekCtrl(d); check("R4 cleared", d, 8'h00);

    // R11 set wins against same-cycle write
    @(negedge clk);
    regAddr = 2'd0; regWrData = 8'h00; regWrEn = 1'b1; tmrOverflow = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tmrOverflow = 1'b0;
    peekCtrl(d); check("R11 set wins", d, 8'h04);
    cpuWrite(2'd0, 8'h00);

    // R6 rising edge timing
    @(negedge clk); extPin = 1'b1;
    @(negedge clk);
    @(negedge clk); peekCtrl(d); check("R6 not yet", d, 8'h00);
    @(negedge clk); peekCtrl(d); check("R6 third edge", d, 8'h02);
    cpuWrite(2'd0, 8'h00);
    @(negedge clk); extPin = 1'b0;
    repeat (5) @(negedge clk);
    peekCtrl(d); check("R6 falling ignored", d, 8'h00);

    // R7 masked pin ignored (mask = pin 0 only)
    @(negedge clk); ioPins = 6'h08;
    repeat (5) @(negedge clk);
    peekCtrl(d); check("R7 masked pin", d, 8'h00);

    // R8 port read returns pins and re-arms
    cpuRead(2'd2, 1'b1, d); check("R8 port value", d, 8'h08);

    // R7 unmasked pin change timing
    @(negedge clk); ioPins = 6'h09;
    @(negedge clk);
    @(negedge clk); peekCtrl(d); check("R7 not yet", d, 8'h00);
    @(negedge clk); peekCtrl(d); check("R7 third edge", d, 8'h01);
    // mismatch still pending: clearing does not stick
    cpuWrite(2'd0, 8'h00);
    peekCtrl(d); check("R7 re-set while pending", d, 8'h01);
    // R8 re-arm then clear sticks
    cpuRead(2'd2, 1'b1, d); check("R8 port after change", d, 8'h09);
    cpuWrite(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    peekCtrl(d); check("R8 re-armed", d, 8'h00);

    // R10 peripheral gating
    cpuWrite(2'd0, 8'h80);
    periphIrq = 1'b1; #1;
    check("R10 no periph enable", {7'd0, irqOut}, 8'h00);
    cpuWrite(2'd0, 8'hC0); #1;
    check("R10 periph passes", {7'd0, irqOut}, 8'h01);
    cpuWrite(2'd0, 8'h40); #1;
    check("R10 master off", {7'd0, irqOut}, 8'h00);
    periphIrq = 1'b0;

    // R2 and R9 random register contents
    for (int i = 0; i < 40; i++) begin
      logic [7:0] v;
      logic p;
      v = 8'($urandom);
      p = 1'($urandom);
      cpuWrite(2'd0, v);
      periphIrq = p;
      peekCtrl(d);
      check("R2 readback", d, v);
      check("R9 irq", {7'd0, irqOut}, {7'd0, expIrq(v, p)});
      // clear flags so the next value starts clean
      cpuWrite(2'd0, 8'h00);
    end
    periphIrq = 1'b0;

    // R3 edge with enables off but flag visible; R9 with enable on
    cpuWrite(2'd0, 8'hA0);
    @(negedge clk); tmrOverflow = 1'b1;
    @(negedge clk); tmrOverflow = 1'b0; #1;
    check("R9 timer irq", {7'd0, irqOut}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule